// File: doc/BRIEF.md
# PCM Sample Level Processor

This block conditions the levels of one voice channel at the 8 kHz frame rate. Each frame delivers one signed 14-bit linear sample on the receive path (R) and one on the send path (S), with a single-cycle frame strobe. The block applies a set of level stages chosen by small static codes and flags. The S input has a stepped attenuator and the S output has a stepped gain. A 6 dB anti-howling attenuator is steered to whichever path the activity flags call for, and a center clip can suppress low-level residue on the S output. The R path carries either a soft level controller or a -6 dB / +6 dB scaling pair that leaves the net level unchanged.

The block sits between the companding converters and the echo-cancelling core. That core, and the activity detection, live outside it. Activity arrives as two flags: R has signal, and S has signal. Control codes are sampled together with the samples at the frame strobe, so a code that changes mid-frame takes effect on the next sample. Results appear one clock after the strobe edge, with a one-cycle valid pulse.

Top module: `pcm_level_proc`

## Requirements
- R1: While reset is asserted and until the first result is produced, `r_out`, `s_out` and `out_vld` are all zero.
- R2: At a clock edge with `frame_stb` high, the samples, codes and flags are captured. `out_vld` is high for exactly the next cycle, and `r_out`/`s_out` hold the results computed from the captured values. Inputs changed after that edge do not affect that result.
- R3: S input attenuation uses `s_att_sel`: 00 passes the sample, 01 applies an arithmetic right shift by 1 (-6 dB), 10 applies a shift by 2 (-12 dB), and 11 behaves as 00. This is the first S stage.
- R4: S output gain uses `s_gain_sel`: 00 passes the sample, 01 doubles it, 10 quadruples it, and 11 behaves as 00. The result saturates to [-8192, 8191]. It follows the attenuator and the R5 pair on the S path.
- R5: With `r_lvl_mode` = 11, each of R and S is shifted right by 1 at its input and doubled with saturation at its output, so R comes out as its input with bit 0 cleared. Modes 00 and 10 leave R unscaled.
- R6: With `r_lvl_mode` = 01, the R sample is chosen by the envelope E of R7. If E ≤ 566 the sample passes. If 566 < E ≤ 1510 the sample is clamped to ±566. If E > 1510 the output is (3·x + 4) >>> 3, which is ×0.375, about -8.5 dB.
- R7: The R envelope resets to 0. Every frame, in every mode, it becomes max(|x|, E − (E >> 3)) using the current sample. R6 uses this updated value.
- R8: With `att_en` high, exactly one 6 dB stage (an arithmetic right shift by 1) is applied. It acts on S, after the gain and before the clip, when `r_act`=1 and `s_act`=0. Otherwise it acts on R as the last R stage. With `att_en` low, neither path is attenuated.
- R9: With `clip_en` high, an S result whose magnitude is below 11 after all other stages is replaced by +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle frame strobe |
| r_in | input | 14 | Receive-path sample, signed |
| s_in | input | 14 | Send-path sample, signed |
| s_att_sel | input | 2 | S input attenuation code |
| s_gain_sel | input | 2 | S output gain code |
| r_lvl_mode | input | 2 | R level mode: 00 off, 01 controller, 10 treated as off, 11 scaling pair |
| att_en | input | 1 | Enables the steered 6 dB attenuator |
| clip_en | input | 1 | Enables the S center clip |
| r_act | input | 1 | R path has signal |
| s_act | input | 1 | S path has signal |
| r_out | output | 14 | Processed receive sample |
| s_out | output | 14 | Processed send sample |
| out_vld | output | 1 | Result valid pulse |

## Verification
The only hidden state that outlives a frame is the R envelope. An error in it shows at `r_out` only in controller mode, and then on the very frame in which the wrong value moves the sample across 566 or 1510. A slow decay error can therefore stay hidden for tens of frames until a mid-band sample is sent. The remaining state is the set of captured codes and flags, and any error there shows on the next valid pulse. The bench sweeps every code and flag combination over samples that reach both saturation rails and the clip floor. It then walks the envelope through its thresholds with directed frames.

// File: rtl/pcm_lvl_pkg.sv
`timescale 1ns/1ps
package pcm_lvl_pkg;
  localparam int SAMP_W = 14;
  localparam int WIDE_W = SAMP_W + 3;

  typedef logic signed [SAMP_W-1:0] samp_t;
  typedef logic signed [WIDE_W-1:0] wide_t;
  typedef logic        [SAMP_W-1:0] mag_t;

  typedef enum logic [1:0] {
    RM_OFF = 2'b00,
    RM_GC  = 2'b01,
    RM_BAD = 2'b10,
    RM_LR  = 2'b11
  } rmode_e;

  localparam samp_t SMAX = samp_t'((1 << (SAMP_W-1)) - 1);
  localparam samp_t SMIN = samp_t'(-(1 << (SAMP_W-1)));

  // left shift by 0..3 with clamping to the sample range
  function automatic samp_t sat_shl(input samp_t x, input logic [1:0] n);
    wide_t w;
    w = wide_t'(x) <<< n;
    if (w > wide_t'(SMAX))      return SMAX;
    else if (w < wide_t'(SMIN)) return SMIN;
    return samp_t'(w);
  endfunction

  function automatic mag_t absv(input samp_t x);
    return x[SAMP_W-1] ? mag_t'(-x) : mag_t'(x);
  endfunction

  // 6 dB step count of a two-bit level code; the spare code means no step
  function automatic logic [1:0] step_of(input logic [1:0] code);
    return (code == 2'b11) ? 2'd0 : code;
  endfunction
endpackage

// File: rtl/pcm_lvl_env.sv
`timescale 1ns/1ps
module pcm_lvl_env
  import pcm_lvl_pkg::*;
#(
  parameter int DECAY_SH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  mag_t mag,
  output mag_t env_nx
);
  mag_t env_q, env_d, decayed;

  always_comb begin
    decayed = env_q - (env_q >> DECAY_SH);
    env_nx  = (mag > decayed) ? mag : decayed;
    env_d   = upd ? env_nx : env_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) env_q <= '0;
    else        env_q <= env_d;
  end

  // R7
  env_decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(upd) |-> env_q >= $past(env_q) - ($past(env_q) >> DECAY_SH));
endmodule

// File: rtl/pcm_lvl_rpath.sv
`timescale 1ns/1ps
module pcm_lvl_rpath
  import pcm_lvl_pkg::*;
#(
  parameter int GC_LO = 566,
  parameter int GC_HI = 1510
) (
  input  samp_t  r_in,
  input  rmode_e mode,
  input  mag_t   env,
  input  logic   att_on,
  output samp_t  r_out
);
  localparam mag_t  LO_M = mag_t'(GC_LO);
  localparam mag_t  HI_M = mag_t'(GC_HI);
  localparam samp_t LO_P = samp_t'(GC_LO);
  localparam samp_t LO_N = samp_t'(-GC_LO);

  samp_t gc_y, lv;
  wide_t w3, wr;

  // soft controller: pass, clamp in the band, x0.375 above it
  always_comb begin
    w3 = (wide_t'(r_in) <<< 1) + wide_t'(r_in) + wide_t'(4);
    wr = w3 >>> 3;
    if (env <= LO_M)      gc_y = r_in;
    else if (env <= HI_M) gc_y = (r_in > LO_P) ? LO_P : ((r_in < LO_N) ? LO_N : r_in);
    else                  gc_y = samp_t'(wr);
  end

  always_comb begin
    unique case (mode)
      RM_LR:   lv = sat_shl(r_in >>> 1, 2'd1);
      RM_GC:   lv = gc_y;
      default: lv = r_in;
    endcase
    r_out = att_on ? (lv >>> 1) : lv;
  end
endmodule

// File: rtl/pcm_lvl_spath.sv
`timescale 1ns/1ps
module pcm_lvl_spath
  import pcm_lvl_pkg::*;
#(
  parameter int CLIP_TH = 11
) (
  input  samp_t      s_in,
  input  logic [1:0] att_sel,
  input  logic [1:0] gain_sel,
  input  logic       lr_on,
  input  logic       att_on,
  input  logic       clip_on,
  output samp_t      s_out
);
  samp_t a_stg, p_stg, b_stg;

  always_comb begin
    a_stg = s_in >>> step_of(att_sel);
    p_stg = lr_on ? sat_shl(a_stg >>> 1, 2'd1) : a_stg;
    b_stg = sat_shl(p_stg, step_of(gain_sel));
    if (att_on) b_stg = b_stg >>> 1;
  end

  generate
    if (CLIP_TH > 0) begin : g_clip
      localparam mag_t TH_M = mag_t'(CLIP_TH);
      always_comb s_out = (clip_on && (absv(b_stg) < TH_M)) ? samp_t'(1) : b_stg;
    end else begin : g_noclip
      assign s_out = b_stg;
    end
  endgenerate
endmodule

// File: rtl/pcm_level_proc.sv
`timescale 1ns/1ps
module pcm_level_proc
  import pcm_lvl_pkg::*;
#(
  parameter int DECAY_SH = 3,
  parameter int GC_LO    = 566,
  parameter int GC_HI    = 1510,
  parameter int CLIP_TH  = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_stb,
  input  logic [13:0] r_in,
  input  logic [13:0] s_in,
  input  logic [1:0]  s_att_sel,
  input  logic [1:0]  s_gain_sel,
  input  logic [1:0]  r_lvl_mode,
  input  logic        att_en,
  input  logic        clip_en,
  input  logic        r_act,
  input  logic        s_act,
  output logic [13:0] r_out,
  output logic [13:0] s_out,
  output logic        out_vld
);
  localparam mag_t LO_M = mag_t'(GC_LO);
  localparam mag_t HI_M = mag_t'(GC_HI);
  localparam mag_t TH_M = mag_t'(CLIP_TH);

  samp_t      r_q, r_d, s_q, s_d;
  logic [1:0] sa_q, sa_d, sg_q, sg_d;
  rmode_e     mode_q, mode_d;
  logic       att_en_q, att_en_d, clip_q, clip_d;
  logic       r_act_q, r_act_d, s_act_q, s_act_d;
  logic       vld_q, vld_d;
  samp_t      r_res, s_res, r_o_q, r_o_d, s_o_q, s_o_d;
  logic       ov_q, ov_d;
  logic       att_on_s, att_on_r;
  mag_t       env_nx;

  // capture stage: next state
  always_comb begin
    r_d = r_q;  s_d = s_q;  sa_d = sa_q;  sg_d = sg_q;  mode_d = mode_q;
    att_en_d = att_en_q;  clip_d = clip_q;  r_act_d = r_act_q;  s_act_d = s_act_q;
    vld_d = frame_stb;
    if (frame_stb) begin
      r_d      = samp_t'(r_in);
      s_d      = samp_t'(s_in);
      sa_d     = s_att_sel;
      sg_d     = s_gain_sel;
      mode_d   = rmode_e'(r_lvl_mode);
      att_en_d = att_en;
      clip_d   = clip_en;
      r_act_d  = r_act;
      s_act_d  = s_act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q <= '0;  s_q <= '0;  sa_q <= '0;  sg_q <= '0;  mode_q <= RM_OFF;
      att_en_q <= 1'b0;  clip_q <= 1'b0;  r_act_q <= 1'b0;  s_act_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      r_q <= r_d;  s_q <= s_d;  sa_q <= sa_d;  sg_q <= sg_d;  mode_q <= mode_d;
      att_en_q <= att_en_d;  clip_q <= clip_d;  r_act_q <= r_act_d;  s_act_q <= s_act_d;
      vld_q <= vld_d;
    end
  end

  // steering of the single anti-howling stage
  always_comb begin
    att_on_s = att_en_q & r_act_q & ~s_act_q;
    att_on_r = att_en_q & ~(r_act_q & ~s_act_q);
  end

  pcm_lvl_env #(.DECAY_SH(DECAY_SH)) env_i (
    .clk(clk), .rst_n(rst_n), .upd(vld_q), .mag(absv(r_q)), .env_nx(env_nx)
  );

  pcm_lvl_rpath #(.GC_LO(GC_LO), .GC_HI(GC_HI)) rpath_i (
    .r_in(r_q), .mode(mode_q), .env(env_nx), .att_on(att_on_r), .r_out(r_res)
  );

  pcm_lvl_spath #(.CLIP_TH(CLIP_TH)) spath_i (
    .s_in(s_q), .att_sel(sa_q), .gain_sel(sg_q), .lr_on(mode_q == RM_LR),
    .att_on(att_on_s), .clip_on(clip_q), .s_out(s_res)
  );

  // output stage: next state
  always_comb begin
    r_o_d = vld_q ? r_res : r_o_q;
    s_o_d = vld_q ? s_res : s_o_q;
    ov_d  = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_o_q <= '0;  s_o_q <= '0;  ov_q <= 1'b0;
    end else begin
      r_o_q <= r_o_d;  s_o_q <= s_o_d;  ov_q <= ov_d;
    end
  end

  assign r_out   = r_o_q;
  assign s_out   = s_o_q;
  assign out_vld = ov_q;

  // R8
  att_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && att_en_q) |-> $onehot({att_on_s, att_on_r}));
  // R8
  att_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !att_en_q) |-> (!att_on_s && !att_on_r));
  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_vld) |-> $past(frame_stb, 2));
  // R5
  lr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && mode_q == RM_LR && !att_on_r) |=> (r_out == {$past(r_q[SAMP_W-1:1]), 1'b0}));
  // R6
  gc_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && mode_q == RM_GC && env_nx > LO_M && env_nx <= HI_M) |=> (absv(samp_t'(r_out)) <= LO_M));
  // R9
  clip_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(clip_q)) |-> (absv(samp_t'(s_out)) >= TH_M || s_out == 14'd1));
endmodule

// File: tb/pcm_level_proc_tb.sv
`timescale 1ns/1ps
module pcm_level_proc_tb_top;
  localparam int LO = 566;
  localparam int HI = 1510;
  localparam int TH = 11;

  logic clk, rst_n, frame_stb;
  logic signed [13:0] r_in, s_in;
  logic [1:0] s_att_sel, s_gain_sel, r_lvl_mode;
  logic att_en, clip_en, r_act, s_act;
  logic signed [13:0] r_out, s_out;
  logic out_vld;

  int total = 0;
  int bad = 0;
  int env_m = 0;
  bit finished = 0;

  pcm_level_proc dut_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .r_in(r_in), .s_in(s_in),
    .s_att_sel(s_att_sel), .s_gain_sel(s_gain_sel), .r_lvl_mode(r_lvl_mode),
    .att_en(att_en), .clip_en(clip_en), .r_act(r_act), .s_act(s_act),
    .r_out(r_out), .s_out(s_out), .out_vld(out_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int sat(input int v);
    if (v > 8191) return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  function automatic int steps(input int code);
    return (code == 3) ? 0 : code;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one frame: strobe, optional mid-frame scramble of controls, check results
  task automatic frame(input int r, input int s, input int sa, input int sg, input int md,
                       input int ae, input int ra, input int sact, input int cl, input bit scr);
    int y, z, mag, dec;
    bit a_s, a_r;
    r_in = 14'(r); s_in = 14'(s);
    s_att_sel = 2'(sa); s_gain_sel = 2'(sg); r_lvl_mode = 2'(md);
    att_en = ae[0]; r_act = ra[0]; s_act = sact[0]; clip_en = cl[0];
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    if (scr) begin
      r_in = ~r_in; s_in = ~s_in; s_att_sel = ~s_att_sel; s_gain_sel = ~s_gain_sel;
      r_lvl_mode = ~r_lvl_mode; att_en = ~att_en; clip_en = ~clip_en;
      r_act = ~r_act; s_act = ~s_act;
    end
    @(negedge clk);
    // expected model from the requirements
    mag = (r < 0) ? -r : r;
    dec = env_m - (env_m >>> 3);
    env_m = (mag > dec) ? mag : dec;
    a_s = (ae != 0) && (ra != 0) && (sact == 0);
    a_r = (ae != 0) && !a_s;
    if (md == 3) y = sat((r >>> 1) * 2);
    else if (md == 1) begin
      if (env_m <= LO) y = r;
      else if (env_m <= HI) y = (r > LO) ? LO : ((r < -LO) ? -LO : r);
      else y = (3 * r + 4) >>> 3;
    end else y = r;
    if (a_r) y = y >>> 1;
    z = s >>> steps(sa);
    if (md == 3) z = sat((z >>> 1) * 2);
    z = sat(z * (1 << steps(sg)));
    if (a_s) z = z >>> 1;
    if (cl != 0 && ((z < 0) ? -z : z) < TH) z = 1;
    check("R2 out_vld", int'(out_vld), 1);
    check((md == 3) ? "R5 r_out" : (md == 1) ? "R6 R7 r_out" : "R8 r_out", int'(r_out), y);
    check("R3 R4 R8 R9 s_out", int'(s_out), z);
  endtask

  int samp_r[8] = '{-8192, 8191, 0, 5, -7, 700, -1200, 3000};
  int samp_s[8] = '{8191, -8192, 3, -9, 0, 2500, -4100, 20};

  initial begin
    frame_stb = 0; r_in = '0; s_in = '0; s_att_sel = '0; s_gain_sel = '0;
    r_lvl_mode = '0; att_en = 0; clip_en = 0; r_act = 0; s_act = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 r_out", int'(r_out), 0);
    check("R1 s_out", int'(s_out), 0);
    check("R1 out_vld", int'(out_vld), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 out_vld idle", int'(out_vld), 0);
    check("R1 r_out idle", int'(r_out), 0);

    // R2: capture at the strobe only; late changes ignored
    frame(1234, -567, 1, 2, 0, 0, 0, 0, 0, 1'b1);
    @(negedge clk);
    check("R2 pulse width", int'(out_vld), 0);
    frame(-3000, 4000, 2, 1, 3, 1, 1, 0, 1, 1'b1);

    // R6/R7: envelope walk through the controller thresholds
    for (int i = 0; i < 40; i++) frame(0, 0, 0, 0, 1, 0, 0, 0, 0, 1'b0);
    frame(1000, 0, 0, 0, 1, 0, 0, 0, 0, 1'b0);   // R6 band clamp to 566
    frame(-900, 0, 0, 0, 1, 0, 0, 0, 0, 1'b0);   // R6 band clamp to -566
    frame(2000, 0, 0, 0, 1, 0, 0, 0, 0, 1'b0);   // R6 above upper threshold
    frame(-2000, 0, 0, 0, 1, 0, 0, 0, 0, 1'b0);
    frame(100, 0, 0, 0, 1, 0, 0, 0, 0, 1'b0);    // R7 held envelope scales a small sample
    for (int i = 0; i < 6; i++) frame(400, 0, 0, 0, 1, 0, 0, 0, 0, 1'b0); // R7 decay into band
    for (int i = 0; i < 20; i++) frame(300, 0, 0, 0, 1, 1, 0, 1, 0, 1'b0); // R7 decay below band

    // R3 R4 R5 R8 R9: sweep every code and flag combination
    for (int sa = 0; sa < 4; sa++)
      for (int sg = 0; sg < 4; sg++)
        for (int md = 0; md < 4; md++)
          for (int fl = 0; fl < 8; fl++)
            for (int cl = 0; cl < 2; cl++)
              for (int k = 0; k < 8; k++)
                frame(samp_r[k], samp_s[k], sa, sg, md, fl & 1, (fl >> 1) & 1, (fl >> 2) & 1, cl, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule